// File: doc/BRIEF.md
# Latency-Delayed Fetch Buffer with Squash

This block sits between instruction fetch and the back end of an out-of-order core. Each cycle, fetch may offer up to `FETCH_WIDTH` entries, one per lane. Each entry carries a sequence number, a destination register count, a fault-marker bit, a serialize-before bit and a privileged-register-access bit. Accepted entries first wait in a staging region. A history of per-cycle accept counts promotes each entry to the output region exactly `LATENCY` clock edges after it was accepted. The back end then drains the output region one entry per cycle through a pop handshake.

The block also counts free physical registers. Registers are taken when an entry is accepted. They come back through a release input when the back end frees them, or directly when entries are squashed. A squash removes every queued entry younger than a given sequence number, searching both regions from the youngest end. A flush empties the block completely and puts it in the idle state. A head entry that must serialize is held back until the reorder buffer reports empty.

Top module: `fetch_delay_buffer`

## Requirements
- R1: After reset, `occupancy` is 0, `free_regs` equals `NUM_PREGS`, `idle` is 1 and `out_valid` is 0.
- R2: On an edge where `in_ready` is high, every lane with `in_valid` set is appended, lane 0 being the oldest. On that edge `occupancy` grows by the number of accepted lanes, `free_regs` drops by the sum of their `in_ndst` values, and `idle` goes to 0 if any lane was accepted.
- R3: An entry accepted at edge k, whether a fault marker or not, moves into the output region at edge k+`LATENCY`, and never earlier. Entries keep their order.
- R4: A `pop` while `out_valid` is high removes the head at the next edge, and the next-oldest entry becomes the head. A `pop` while `out_valid` is low changes nothing.
- R5: Suppose the head of the output region has its serialize bit or its privileged-access bit set. Then `out_valid` stays low while `rob_empty` is low. When `rob_empty` is high, the head is offered like any other entry.
- R6: `in_ready` is high exactly when all of these hold: `squash` is low, `flush` is low, `occupancy`+`FETCH_WIDTH` is at most `MAX_BUF`, and `free_regs` is greater than `FETCH_WIDTH`*(2^`DST_W`-1).
- R7: A `squash` with value s removes every queued entry whose sequence number is greater than s. The `in_ndst` of each removed entry is returned to `free_regs`. All surviving entries are in the output region after that edge, and `pop` is ignored on that edge.
- R8: `flush` empties both regions, returns every queued entry's registers, and sets `idle` to 1. It takes priority over `squash`.
- R9: On every edge, `free_regs` also grows by `rel_cnt`, whatever else happens on that edge.
- R10: `occupancy` never exceeds `MAX_BUF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | FETCH_WIDTH | Per-lane entry offered |
| in_seq | input | FETCH_WIDTH*SEQ_W | Per-lane sequence number |
| in_ndst | input | FETCH_WIDTH*DST_W | Per-lane destination register count |
| in_fault | input | FETCH_WIDTH | Per-lane fault-marker bit |
| in_ser | input | FETCH_WIDTH | Per-lane serialize-before bit |
| in_ipr | input | FETCH_WIDTH | Per-lane privileged-access bit |
| in_ready | output | 1 | All offered lanes are taken this cycle |
| rel_cnt | input | REL_W | Registers released by the back end |
| squash | input | 1 | Remove entries younger than squash_seq |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| flush | input | 1 | Empty everything and go idle |
| rob_empty | input | 1 | Reorder buffer is empty |
| pop | input | 1 | Back end takes the head |
| out_valid | output | 1 | Head is offered |
| out_seq | output | SEQ_W | Head sequence number |
| out_ndst | output | DST_W | Head destination register count |
| out_fault | output | 1 | Head is a fault marker |
| out_ipr | output | 1 | Head is a privileged access |
| occupancy | output | $clog2(MAX_BUF+1) | Entries held in both regions |
| free_regs | output | $clog2(NUM_PREGS+1) | Free physical register count |
| idle | output | 1 | No entry accepted since reset or flush |

## Verification
The hardest case to reach is a squash that lands while entries are still in staging, with their promotion edge still pending, and the output head is held by the serialize gate. Only that mix shows whether survivors are promoted correctly and whether the withheld head stays put. The stimulus first fills the buffer with popping disabled until `in_ready` drops. It then runs a long mixed phase. In that phase, serializing entries are common, `rob_empty` toggles about half the time, and squash points are drawn within a few sequence numbers of the youngest fetched entry. Most squashes therefore cut through the staging region rather than beyond it.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
  // control action applied at a clock edge, highest priority first
  typedef enum logic [1:0] {
    ACT_FLUSH  = 2'd0,
    ACT_SQUASH = 2'd1,
    ACT_RUN    = 2'd2
  } fdb_act_e;
endpackage

// File: rtl/fdb_delay_history.sv
module fdb_delay_history #(
  parameter int LATENCY = 3,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] add,
  output logic [CW-1:0] due
);
  localparam int SLOTS = LATENCY + 1;
  localparam int IW    = $clog2(SLOTS);

  logic [CW-1:0] slot [SLOTS];
  logic [IW-1:0] cur, nxt;

  always_comb begin
    nxt = (int'(cur) == SLOTS - 1) ? '0 : cur + 1'b1;
    due = slot[nxt];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < SLOTS; s++) slot[s] <= '0;
      cur <= '0;
    end else begin
      slot[cur] <= add;
      slot[nxt] <= '0;
      cur       <= nxt;
    end
  end

  AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (due == '0)); // R7
endmodule

// File: rtl/fdb_ring.sv
module fdb_ring #(
  parameter int DEPTH = 8,
  parameter int FW    = 2,
  parameter int SW    = 16,
  parameter int DW    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = DW + CW
) (
  input  logic             clk,
  input  logic [FW-1:0]    wr_en,
  input  logic [AW-1:0]    wr_base,
  input  logic [FW*SW-1:0] wr_seq,
  input  logic [FW*DW-1:0] wr_ndst,
  input  logic [FW-1:0]    wr_fault,
  input  logic [FW-1:0]    wr_ser,
  input  logic [FW-1:0]    wr_ipr,
  input  logic [AW-1:0]    head,
  input  logic [CW-1:0]    live,
  input  logic [SW-1:0]    thresh,
  input  logic             kill_all,
  output logic [SW-1:0]    rd_seq,
  output logic [DW-1:0]    rd_ndst,
  output logic             rd_fault,
  output logic             rd_ser,
  output logic             rd_ipr,
  output logic [CW-1:0]    keep,
  output logic [RW-1:0]    ret
);
  logic [SW-1:0] m_seq   [DEPTH];
  logic [DW-1:0] m_ndst  [DEPTH];
  logic          m_fault [DEPTH];
  logic          m_ser   [DEPTH];
  logic          m_ipr   [DEPTH];
  logic [AW-1:0] off     [FW];

  always_comb begin
    logic [AW-1:0] run;
    run = '0;
    for (int i = 0; i < FW; i++) begin
      off[i] = run;
      run    = run + AW'(wr_en[i]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < FW; i++) begin
      if (wr_en[i]) begin
        m_seq[wr_base + off[i]]   <= wr_seq[i*SW +: SW];
        m_ndst[wr_base + off[i]]  <= wr_ndst[i*DW +: DW];
        m_fault[wr_base + off[i]] <= wr_fault[i];
        m_ser[wr_base + off[i]]   <= wr_ser[i];
        m_ipr[wr_base + off[i]]   <= wr_ipr[i];
      end
    end
  end

  always_comb begin
    rd_seq   = m_seq[head];
    rd_ndst  = m_ndst[head];
    rd_fault = m_fault[head];
    rd_ser   = m_ser[head];
    rd_ipr   = m_ipr[head];
  end

  // sequence numbers rise from head to tail, so the survivors form a prefix
  always_comb begin
    logic [AW-1:0] idx;
    keep = '0;
    ret  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + AW'(k);
      if (k < int'(live)) begin
        if (!kill_all && m_seq[idx] <= thresh) keep = keep + 1'b1;
        else ret = ret + RW'(m_ndst[idx]);
      end
    end
  end
endmodule

// File: rtl/fetch_delay_buffer.sv
module fetch_delay_buffer #(
  parameter int LATENCY     = 3,
  parameter int FETCH_WIDTH = 2,
  parameter int MAX_BUF     = 8,
  parameter int SEQ_W       = 16,
  parameter int DST_W       = 2,
  parameter int NUM_PREGS   = 24,
  parameter int REL_W       = 3,
  localparam int AW   = $clog2(MAX_BUF),
  localparam int CW   = $clog2(MAX_BUF + 1),
  localparam int FRW  = $clog2(NUM_PREGS + 1),
  localparam int RW   = DST_W + CW,
  localparam int MAXD = (1 << DST_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [FETCH_WIDTH-1:0]    in_valid,
  input  logic [FETCH_WIDTH*SEQ_W-1:0] in_seq,
  input  logic [FETCH_WIDTH*DST_W-1:0] in_ndst,
  input  logic [FETCH_WIDTH-1:0]    in_fault,
  input  logic [FETCH_WIDTH-1:0]    in_ser,
  input  logic [FETCH_WIDTH-1:0]    in_ipr,
  output logic                      in_ready,
  input  logic [REL_W-1:0]          rel_cnt,
  input  logic                      squash,
  input  logic [SEQ_W-1:0]          squash_seq,
  input  logic                      flush,
  input  logic                      rob_empty,
  input  logic                      pop,
  output logic                      out_valid,
  output logic [SEQ_W-1:0]          out_seq,
  output logic [DST_W-1:0]          out_ndst,
  output logic                      out_fault,
  output logic                      out_ipr,
  output logic [CW-1:0]             occupancy,
  output logic [FRW-1:0]            free_regs,
  output logic                      idle
);
  import fdb_pkg::*;

  logic [AW-1:0]          head;
  logic [CW-1:0]          n_out, n_stg, nacc, due, mv, keep;
  logic [RW-1:0]          ret, enq_sum;
  logic [FETCH_WIDTH-1:0] lane_we;
  logic                   rd_ser, pop_fire;
  fdb_act_e               act;

  always_comb begin
    occupancy = n_out + n_stg;
    in_ready  = !squash && !flush
             && (int'(occupancy) + FETCH_WIDTH <= MAX_BUF)
             && (int'(free_regs) > FETCH_WIDTH * MAXD);
    lane_we   = in_ready ? in_valid : '0;
    nacc      = '0;
    enq_sum   = '0;
    for (int i = 0; i < FETCH_WIDTH; i++) begin
      if (lane_we[i]) begin
        nacc    = nacc + 1'b1;
        enq_sum = enq_sum + RW'(in_ndst[i*DST_W +: DST_W]);
      end
    end
    act       = flush ? ACT_FLUSH : (squash ? ACT_SQUASH : ACT_RUN);
    out_valid = (n_out != '0) && !((rd_ser || out_ipr) && !rob_empty);
    pop_fire  = pop && out_valid && (act == ACT_RUN);
    mv        = (due < n_stg) ? due : n_stg;
  end

  fdb_ring #(
    .DEPTH(MAX_BUF), .FW(FETCH_WIDTH), .SW(SEQ_W), .DW(DST_W)
  ) u_ring (
    .clk(clk), .wr_en(lane_we), .wr_base(head + occupancy[AW-1:0]),
    .wr_seq(in_seq), .wr_ndst(in_ndst), .wr_fault(in_fault),
    .wr_ser(in_ser), .wr_ipr(in_ipr),
    .head(head), .live(occupancy), .thresh(squash_seq), .kill_all(flush),
    .rd_seq(out_seq), .rd_ndst(out_ndst), .rd_fault(out_fault),
    .rd_ser(rd_ser), .rd_ipr(out_ipr), .keep(keep), .ret(ret)
  );

  fdb_delay_history #(.LATENCY(LATENCY), .CW(CW)) u_hist (
    .clk(clk), .rst(rst), .clr(act != ACT_RUN), .add(nacc), .due(due)
  );

  always_ff @(posedge clk) begin
    int fn;
    fn = int'(free_regs) + int'(rel_cnt);
    if (rst) begin
      head      <= '0;
      n_out     <= '0;
      n_stg     <= '0;
      free_regs <= FRW'(NUM_PREGS);
      idle      <= 1'b1;
    end else begin
      case (act)
        ACT_FLUSH: begin
          n_out     <= '0;
          n_stg     <= '0;
          idle      <= 1'b1;
          free_regs <= FRW'(fn + int'(ret));
        end
        ACT_SQUASH: begin
          n_out     <= keep;
          n_stg     <= '0;
          free_regs <= FRW'(fn + int'(ret));
        end
        default: begin
          head      <= head + AW'(pop_fire);
          n_out     <= n_out - CW'(pop_fire) + mv;
          n_stg     <= n_stg - mv + nacc;
          free_regs <= FRW'(fn - int'(enq_sum));
          if (nacc != '0) idle <= 1'b0;
        end
      endcase
    end
  end

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= MAX_BUF); // R10
  AST_FREE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(free_regs) <= NUM_PREGS); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occupancy == '0 && idle)); // R8
  AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (squash && !flush) |=> (occupancy <= $past(occupancy))); // R7
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !rob_empty) |-> !(rd_ser || out_ipr)); // R5
endmodule

// File: tb/fetch_delay_buffer_test.sv
module fetch_delay_buffer_test;
  localparam int PERIOD = 10;
  localparam int LAT = 3, FW = 2, MB = 8, SW = 16, DW = 2, NP = 24, RLW = 3;
  localparam int CW = $clog2(MB + 1), FRW = $clog2(NP + 1);
  localparam int NCYC = 4000;

  typedef struct {
    int seq; int ndst; bit fault; bit ser; bit ipr; int due;
  } ent_t;

  logic clk = 0, rst = 1;
  logic [FW-1:0] in_valid = '0, in_fault = '0, in_ser = '0, in_ipr = '0;
  logic [FW*SW-1:0] in_seq = '0;
  logic [FW*DW-1:0] in_ndst = '0;
  logic in_ready, squash = 0, flush = 0, rob_empty = 1, pop = 0;
  logic [RLW-1:0] rel_cnt = '0;
  logic [SW-1:0] squash_seq = '0;
  logic out_valid, out_fault, out_ipr, idle;
  logic [SW-1:0] out_seq;
  logic [DW-1:0] out_ndst;
  logic [CW-1:0] occupancy;
  logic [FRW-1:0] free_regs;

  int checks = 0, errors = 0;
  bit done = 0;

  ent_t stg[$], outq[$];
  int mfree, pool, edge_no, next_seq;
  bit midle;

  always #(PERIOD / 2) clk = ~clk;

  fetch_delay_buffer #(.LATENCY(LAT), .FETCH_WIDTH(FW), .MAX_BUF(MB),
    .SEQ_W(SW), .DST_W(DW), .NUM_PREGS(NP), .REL_W(RLW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_seq(in_seq),
    .in_ndst(in_ndst), .in_fault(in_fault), .in_ser(in_ser), .in_ipr(in_ipr),
    .in_ready(in_ready), .rel_cnt(rel_cnt), .squash(squash),
    .squash_seq(squash_seq), .flush(flush), .rob_empty(rob_empty), .pop(pop),
    .out_valid(out_valid), .out_seq(out_seq), .out_ndst(out_ndst),
    .out_fault(out_fault), .out_ipr(out_ipr), .occupancy(occupancy),
    .free_regs(free_regs), .idle(idle));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, edge_no);
    end
  endtask

  function automatic bit exp_ready();
    return !squash && !flush && (stg.size() + outq.size() + FW <= MB)
        && (mfree > FW * ((1 << DW) - 1));
  endfunction

  function automatic bit exp_ovalid();
    if (outq.size() == 0) return 0;
    return !((outq[0].ser || outq[0].ipr) && !rob_empty);
  endfunction

  task automatic model_edge();
    int ret;
    bit ov, rdy;
    ov = exp_ovalid();
    rdy = exp_ready();
    ret = 0;
    if (flush) begin
      foreach (stg[i]) ret += stg[i].ndst;
      foreach (outq[i]) ret += outq[i].ndst;
      stg.delete(); outq.delete();
      midle = 1;
      mfree += ret + int'(rel_cnt);
    end else if (squash) begin
      while (stg.size() > 0 && stg[$].seq > int'(squash_seq)) begin
        ret += stg[$].ndst; void'(stg.pop_back());
      end
      while (stg.size() == 0 && outq.size() > 0 && outq[$].seq > int'(squash_seq)) begin
        ret += outq[$].ndst; void'(outq.pop_back());
      end
      while (stg.size() > 0) outq.push_back(stg.pop_front());
      mfree += ret + int'(rel_cnt);
      next_seq = int'(squash_seq) + 1;
    end else begin
      if (pop && ov) pool += outq.pop_front().ndst;
      while (stg.size() > 0 && stg[0].due <= edge_no) outq.push_back(stg.pop_front());
      if (rdy) begin
        for (int i = 0; i < FW; i++) if (in_valid[i]) begin
          ent_t e;
          e.seq = int'(in_seq[i*SW +: SW]); e.ndst = int'(in_ndst[i*DW +: DW]);
          e.fault = in_fault[i]; e.ser = in_ser[i]; e.ipr = in_ipr[i];
          e.due = edge_no + LAT;
          stg.push_back(e);
          mfree -= e.ndst;
          midle = 0;
          next_seq++;
        end
      end
      mfree += int'(rel_cnt);
    end
    edge_no++;
  endtask

  task automatic compare();
    chk("R6 in_ready", int'(in_ready), int'(exp_ready()));
    chk("R3 R5 out_valid", int'(out_valid), int'(exp_ovalid()));
    if (out_valid && outq.size() > 0) begin
      chk("R4 out_seq", int'(out_seq), outq[0].seq);
      chk("R3 out_fault", int'(out_fault), int'(outq[0].fault));
    end
    chk("R2 R7 occupancy", int'(occupancy), stg.size() + outq.size());
    chk("R9 free_regs", int'(free_regs), mfree);
    chk("R8 idle", int'(idle), int'(midle));
    chk("R10 occupancy bound", int'(int'(occupancy) <= MB), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    mfree = NP; midle = 1; pool = 0; edge_no = 0; next_seq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 free_regs", int'(free_regs), NP);
    chk("R1 idle", int'(idle), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    rst = 0;
    for (int c = 0; c < NCYC; c++) begin
      bit fill;
      fill = (c < 40);
      // offered lanes use consecutive sequence numbers
      k = next_seq;
      for (int i = 0; i < FW; i++) begin
        in_valid[i] = ($urandom % 4) != 0;
        in_seq[i*SW +: SW] = SW'(k);
        if (in_valid[i]) k++;
        in_ndst[i*DW +: DW] = DW'($urandom % 4);
        in_fault[i] = ($urandom % 10) == 0;
        in_ser[i] = ($urandom % 6) == 0;
        in_ipr[i] = ($urandom % 12) == 0;
      end
      pop = !fill && (($urandom % 10) < 6);
      rob_empty = fill || (($urandom % 2) == 0);
      squash = !fill && (($urandom % 25) == 0);
      flush = !fill && (($urandom % 120) == 0);
      squash_seq = SW'((next_seq > 6) ? next_seq - 1 - int'($urandom % 6) : 0);
      k = (pool < 7) ? pool : 7;
      rel_cnt = RLW'((k > 0) ? int'($urandom % (k + 1)) : 0);
      pool -= int'(rel_cnt);
      #1;
      compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
    compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule